// File: doc/BRIEF.md
# Incremental Encoder Front End

This block sits between the raw signal lines of an incremental encoder and a position counter. It brings the A, B and index lines into the system clock domain through a two-stage synchroniser. It then runs each line through a majority-free stability filter clocked by a programmable sampling tick. From the cleaned levels it produces a count strobe together with a direction bit. A downstream counter adds or subtracts one on each strobe.

Two families of decoding are offered. The quadrature family turns the two-phase Gray sequence on A/B into counts at one, two or four counts per encoder line. The count/direction family takes A as a pulse input and B as the direction level. The index line is reported as an edge event of selectable polarity in quadrature decoding, and as a low-level indication in count/direction decoding. An A/B update that jumps over a Gray step is reported as noise.

Top module: `qenc_front`

## Requirements
- R1: The filter samples its lines once every `prescale` system clock cycles, with a value of 0 treated as 1. With the synchroniser, a change on A therefore reaches `cnt_stb` no sooner than 2·prescale cycles and no later than 3·prescale+6 cycles.
- R2: In quadrature decoding, a level on A, B or index is accepted only after it has been seen on 3 consecutive filter samples. With prescale 1, a 2-cycle pulse has no effect and a 3-cycle pulse is accepted.
- R3: With `mode_sel` = 2'b00 (four-count decoding, the value a zero tie selects), every valid Gray step of (A,B) through 00, 10, 11, 01 gives exactly one single-cycle `cnt_stb`. Eight full cycles give 32 strobes.
- R4: With `mode_sel` = 2'b01 (two-count decoding), only the valid steps that change A give a strobe.
- R5: With `mode_sel` = 2'b10 (one-count decoding), only the steps between (A,B)=00 and (A,B)=10 give a strobe.
- R6: In quadrature decoding, a step forward in the order 00→10→11→01→00 sets `cnt_up` to 1 with its strobe, and a backward step sets it to 0. `cnt_up` changes only together with a strobe and otherwise holds its value.
- R7: With `mode_sel` = 2'b11 (count/direction), A is not filtered. Each rising edge of A gives one strobe, with `cnt_up` equal to B.
- R8: In quadrature decoding, an update in which A and B change together raises `noise_err` for one cycle and gives no strobe. In count/direction decoding, `noise_err` stays low.
- R9: In quadrature decoding with `idx_en` = 1, `idx_evt` pulses once on a rising edge of the filtered index when `idx_pol` = 1, and once on a falling edge when `idx_pol` = 0.
- R10: In count/direction decoding with `idx_en` = 1, `idx_evt` is high in every cycle that the synchronised index is low, whatever `idx_pol` is.
- R11: With `idx_en` = 0, the index input is taken as high and `idx_evt` never asserts.
- R12: While reset is held and right after it, `cnt_stb`, `cnt_up`, `idx_evt` and `noise_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Raw encoder phase A (count pulse in count/direction decoding) |
| enc_b | input | 1 | Raw encoder phase B (direction level in count/direction decoding) |
| enc_idx | input | 1 | Raw encoder index line |
| mode_sel | input | 2 | 00 four-count, 01 two-count, 10 one-count, 11 count/direction |
| prescale | input | PRESC_W | Filter sampling period in system clocks (0 acts as 1) |
| idx_en | input | 1 | Index enable |
| idx_pol | input | 1 | Index edge: 1 rising, 0 falling (quadrature only) |
| cnt_stb | output | 1 | Single-cycle count strobe |
| cnt_up | output | 1 | Direction of the latest strobe, 1 is up |
| idx_evt | output | 1 | Index event |
| noise_err | output | 1 | Single-cycle illegal-transition indication |

## Verification
The hardest situation to reach is an illegal Gray jump. The filter normally keeps A and B edges apart, so a double change only appears when both filtered lines switch on the same sampling tick. The stimulus reaches this by driving A and B in the same cycle with prescale 1, so both lines pass the synchroniser and the 3-sample window together. The same pair of edges is then repeated in count/direction decoding to show that no error is raised there. The filter window boundary is reached with pulses of exactly 2 and 3 cycles. The prescaler is measured by timing the gap from an A edge to its strobe.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    QM_X4     = 2'b00,
    QM_X2     = 2'b01,
    QM_X1     = 2'b10,
    QM_CNTDIR = 2'b11
  } qmode_e;

  localparam int NLINES = 3;
  localparam int LN_A   = 0;
  localparam int LN_B   = 1;
  localparam int LN_I   = 2;

  // Position of an (A,B) pair in the forward Gray cycle 00,10,11,01
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_pos = 2'd0;
      2'b10:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction

  function automatic logic step_is_up(input logic [1:0] from_ab, input logic [1:0] to_ab);
    step_is_up = (gray_pos(to_ab) == gray_pos(from_ab) + 2'd1);
  endfunction

  // Whether a valid single-line step produces a count in the given mode
  function automatic logic step_counts(input qmode_e m, input logic [1:0] from_ab,
                                       input logic [1:0] to_ab);
    case (m)
      QM_X4:   step_counts = 1'b1;
      QM_X2:   step_counts = from_ab[1] ^ to_ab[1];
      QM_X1:   step_counts = (from_ab[1] ^ to_ab[1]) & ~from_ab[0] & ~to_ab[0];
      default: step_counts = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/qenc_tick_gen.sv
module qenc_tick_gen #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] prescale,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt;
  logic [PRESC_W-1:0] last_cnt;
  logic               wrap;

  assign last_cnt = (prescale == '0) ? '0 : prescale - 1'b1;
  assign wrap     = (cnt >= last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prescale > 1) |=> !tick); // R1
endmodule

// File: rtl/qenc_glitch_filter.sv
module qenc_glitch_filter #(
  parameter int   LEN     = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] hist;
  logic [LEN-1:0] hist_nxt;

  assign hist_nxt = {hist[LEN-2:0], din};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= {LEN{RST_VAL}};
      dout <= RST_VAL;
    end else if (tick) begin
      hist <= hist_nxt;
      if (&hist_nxt)       dout <= 1'b1;
      else if (~|hist_nxt) dout <= 1'b0;
    end
  end

  AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(tick)); // R2
  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(din) == dout)); // R2
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
  import qenc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  qmode_e mode,
  input  logic   idx_en,
  input  logic   idx_pol,
  input  logic   line_a,
  input  logic   line_b,
  input  logic   line_i,
  output logic   cnt_stb,
  output logic   cnt_up,
  output logic   idx_evt,
  output logic   noise_err
);
  logic       prev_a, prev_b, prev_i;
  logic [1:0] ab_old, ab_new;
  logic       quad, chg_a, chg_b;
  logic       ev_step, ev_jump, ev_count, ev_up;
  logic       eff_i, ev_idx;

  assign quad   = (mode != QM_CNTDIR);
  assign ab_old = {prev_a, prev_b};
  assign ab_new = {line_a, line_b};
  assign chg_a  = line_a ^ prev_a;
  assign chg_b  = line_b ^ prev_b;
  assign eff_i  = idx_en ? line_i : 1'b1;

  always_comb begin
    ev_step = chg_a ^ chg_b;
    ev_jump = quad & chg_a & chg_b;
    if (quad) begin
      ev_count = ev_step & step_counts(mode, ab_old, ab_new);
      ev_up    = step_is_up(ab_old, ab_new);
      ev_idx   = idx_pol ? (eff_i & ~prev_i) : (~eff_i & prev_i);
    end else begin
      ev_count = line_a & ~prev_a;
      ev_up    = line_b;
      ev_idx   = ~line_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_a    <= 1'b0;
      prev_b    <= 1'b0;
      prev_i    <= 1'b1;
      cnt_stb   <= 1'b0;
      cnt_up    <= 1'b0;
      idx_evt   <= 1'b0;
      noise_err <= 1'b0;
    end else begin
      prev_a    <= line_a;
      prev_b    <= line_b;
      prev_i    <= eff_i;
      cnt_stb   <= ev_count;
      if (ev_count) cnt_up <= ev_up;
      idx_evt   <= idx_en & ev_idx;
      noise_err <= ev_jump;
    end
  end

  AST_NO_STB_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_stb && noise_err)); // R8
  AST_ERR_QUAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    noise_err |-> ($past(mode) != QM_CNTDIR)); // R8
  AST_IDX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |-> $past(idx_en)); // R11
  AST_CD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_stb && $past(mode) == QM_CNTDIR) |-> (cnt_up == $past(line_b))); // R7
  AST_DIR_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up != $past(cnt_up)) |-> cnt_stb); // R6
endmodule

// File: rtl/qenc_front.sv
module qenc_front
  import qenc_pkg::*;
#(
  parameter int PRESC_W  = 8,
  parameter int FILT_LEN = 3,
  parameter int SYNC_LEN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_a,
  input  logic               enc_b,
  input  logic               enc_idx,
  input  logic [1:0]         mode_sel,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               idx_en,
  input  logic               idx_pol,
  output logic               cnt_stb,
  output logic               cnt_up,
  output logic               idx_evt,
  output logic               noise_err
);
  localparam logic [NLINES-1:0] IDLE_LVL = NLINES'(1) << LN_I;

  qmode_e            mode;
  logic              tick;
  logic [NLINES-1:0] raw_lines, sync_lines, filt_lines, sel_lines;

  assign mode      = qmode_e'(mode_sel);
  assign raw_lines = {enc_idx, enc_b, enc_a};

  qenc_sync #(.W(NLINES), .STAGES(SYNC_LEN), .RST_VAL(IDLE_LVL)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(raw_lines), .dout(sync_lines));

  qenc_tick_gen #(.PRESC_W(PRESC_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .tick(tick));

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    qenc_glitch_filter #(.LEN(FILT_LEN), .RST_VAL(IDLE_LVL[g])) filt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .din(sync_lines[g]), .dout(filt_lines[g]));
    assign sel_lines[g] = (mode == QM_CNTDIR) ? sync_lines[g] : filt_lines[g];
  end

  qenc_step_decode dec_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .idx_en(idx_en), .idx_pol(idx_pol),
    .line_a(sel_lines[LN_A]), .line_b(sel_lines[LN_B]), .line_i(sel_lines[LN_I]),
    .cnt_stb(cnt_stb), .cnt_up(cnt_up), .idx_evt(idx_evt), .noise_err(noise_err));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(cnt_stb || idx_evt || noise_err)); // R12
endmodule

// File: tb/qenc_front_tb_top.sv
module qenc_front_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic [7:0] prescale = 8'd1;
  logic idx_en = 1'b0, idx_pol = 1'b1;
  logic cnt_stb, cnt_up, idx_evt, noise_err;

  int n_chk = 0, n_err = 0;
  int c_stb = 0, c_up = 0, c_dn = 0, c_ne = 0, c_idx = 0;
  int pos = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qenc_front dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .mode_sel(mode_sel), .prescale(prescale), .idx_en(idx_en), .idx_pol(idx_pol),
    .cnt_stb(cnt_stb), .cnt_up(cnt_up), .idx_evt(idx_evt), .noise_err(noise_err));

  always @(negedge clk) if (rst_n) begin
    if (cnt_stb) begin c_stb++; if (cnt_up) c_up++; else c_dn++; end
    if (noise_err) c_ne++;
    if (idx_evt) c_idx++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk);
    c_stb = 0; c_up = 0; c_dn = 0; c_ne = 0; c_idx = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Gray position to lines: a = p0 xor p1, b = p1
  task automatic go_pos(input int p);
    @(negedge clk);
    enc_a = p[0] ^ p[1];
    enc_b = p[1];
    pos = p;
    idle(12);
  endtask

  function automatic int a_of(input int p); return (p == 1 || p == 2) ? 1 : 0; endfunction

  task automatic measure(input int p, input int lo, input int hi);
    int lat = 0;
    prescale = p[7:0];
    idle(4 * (p + 2));
    clr();
    @(negedge clk);
    enc_a = ~enc_a;
    while (!cnt_stb && lat < 200) begin @(negedge clk); lat++; end
    pos = enc_a ? 1 : 0;
    chk($sformatf("R1 latency lower p=%0d", p), (lat >= lo) ? 1 : 0, 1);
    chk($sformatf("R1 latency upper p=%0d (lat %0d)", p, lat), (lat <= hi) ? 1 : 0, 1);
  endtask

  initial begin
    #1500us;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R12 outputs in reset", {cnt_stb, cnt_up, idx_evt, noise_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    chk("R12 outputs after reset", {cnt_stb, cnt_up, idx_evt, noise_err}, 0);
    idle(10);

    // exhaustive single steps: three quadrature modes x four positions x two directions
    for (int m = 0; m < 3; m++) begin
      mode_sel = m[1:0];
      for (int s = 0; s < 4; s++) begin
        for (int d = 0; d < 2; d++) begin
          int nxt, hit;
          while (pos != s) go_pos((pos + 1) % 4);
          clr();
          nxt = d ? (s + 1) % 4 : (s + 3) % 4;
          if (m == 0) hit = 1;
          else if (m == 1) hit = (a_of(s) != a_of(nxt)) ? 1 : 0;
          else hit = (s < 2 && nxt < 2) ? 1 : 0;
          go_pos(nxt);
          chk($sformatf("%s R6 up m=%0d s=%0d d=%0d", m == 0 ? "R3" : (m == 1 ? "R4" : "R5"), m, s, d),
              c_up, hit * d);
          chk($sformatf("R6 down m=%0d s=%0d d=%0d", m, s, d), c_dn, hit * (1 - d));
          chk("R8 no error on valid step", c_ne, 0);
        end
      end
    end

    mode_sel = 2'b00;
    go_pos(0);
    clr();
    for (int k = 0; k < 32; k++) go_pos((pos + 1) % 4);
    chk("R3 eight cycles forward", c_up, 32);
    idle(20);
    chk("R6 direction held up", cnt_up, 1);
    mode_sel = 2'b10;
    clr();
    for (int k = 0; k < 32; k++) go_pos((pos + 3) % 4);
    chk("R5 eight cycles backward", c_dn, 8);
    idle(20);
    chk("R6 direction held down", cnt_up, 0);

    // filter window at prescale 1
    mode_sel = 2'b00;
    clr();
    @(negedge clk); enc_a = 1'b1; idle(2); enc_a = 1'b0; idle(12);
    chk("R2 two-cycle pulse rejected", c_stb, 0);
    clr();
    @(negedge clk); enc_a = 1'b1; idle(3); enc_a = 1'b0; idle(12);
    chk("R2 three-cycle pulse accepted", c_stb, 2);

    // illegal jump
    clr();
    @(negedge clk); enc_a = 1'b1; enc_b = 1'b1; idle(12);
    @(negedge clk); enc_a = 1'b0; enc_b = 1'b0; idle(12);
    chk("R8 jump errors", c_ne, 2);
    chk("R8 jump no strobe", c_stb, 0);

    // count/direction
    mode_sel = 2'b11;
    idle(4);
    clr();
    enc_b = 1'b1;
    for (int k = 0; k < 5; k++) begin @(negedge clk); enc_a = 1'b1; idle(2); enc_a = 1'b0; idle(2); end
    enc_b = 1'b0;
    for (int k = 0; k < 3; k++) begin @(negedge clk); enc_a = 1'b1; idle(2); enc_a = 1'b0; idle(2); end
    idle(6);
    chk("R7 up pulses", c_up, 5);
    chk("R7 down pulses", c_dn, 3);
    clr();
    @(negedge clk); enc_a = 1'b1; enc_b = 1'b1; idle(6);
    @(negedge clk); enc_a = 1'b0; enc_b = 1'b0; idle(6);
    chk("R8 no error in count/direction", c_ne, 0);
    chk("R7 strobe on joint edge", c_stb, 1);

    // index, count/direction level
    idx_en = 1'b1;
    for (int pl = 0; pl < 2; pl++) begin
      idx_pol = pl[0];
      clr();
      @(negedge clk); enc_idx = 1'b0; idle(6); enc_idx = 1'b1; idle(6);
      chk($sformatf("R10 low level cycles pol=%0d", pl), c_idx, 6);
    end
    idx_en = 1'b0;
    clr();
    @(negedge clk); enc_idx = 1'b0; idle(6); enc_idx = 1'b1; idle(6);
    chk("R11 disabled level", c_idx, 0);

    // index, quadrature edges
    mode_sel = 2'b00;
    idle(8);
    idx_en = 1'b1;
    idx_pol = 1'b1;
    clr(); @(negedge clk); enc_idx = 1'b0; idle(12);
    chk("R9 rising pol ignores fall", c_idx, 0);
    clr(); @(negedge clk); enc_idx = 1'b1; idle(12);
    chk("R9 rising pol sees rise", c_idx, 1);
    idx_pol = 1'b0;
    clr(); @(negedge clk); enc_idx = 1'b0; idle(12);
    chk("R9 falling pol sees fall", c_idx, 1);
    clr(); @(negedge clk); enc_idx = 1'b1; idle(12);
    chk("R9 falling pol ignores rise", c_idx, 0);
    clr(); @(negedge clk); enc_idx = 1'b0; idle(2); enc_idx = 1'b1; idle(12);
    chk("R2 short index pulse rejected", c_idx, 0);
    idx_en = 1'b0;
    clr();
    @(negedge clk); enc_idx = 1'b0; idle(12); enc_idx = 1'b1; idle(12);
    chk("R11 disabled edges", c_idx, 0);

    // prescaler timing
    enc_a = 1'b0; enc_b = 1'b0;
    idle(12);
    measure(17, 34, 57);
    measure(5, 10, 21);
    measure(0, 2, 9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule